// File: doc/BRIEF.md
# Cascaded Time-of-Day Counter

This block keeps time of day as three synchronous digit counters chained together. A seconds stage counts modulo 60, a minutes stage counts modulo 60 and an hours stage counts modulo 24. All three stages run on one clock. The caller supplies a one-cycle `tick` for each elapsed second. A stage advances only in a cycle where its increment request is high.

Each stage has a wrap output. Wrap is a Mealy signal: it is high in the cycle where the stage's increment request is high, clear is low and the stage holds its last value. That wrap is the increment request of the next stage up, so a carry passes through all stages within one clock and all of them update on the same edge.

The wrap of the hours stage leaves the block as a one-cycle day carry. A shared synchronous clear returns every stage to zero. The clear wins over any tick in the same cycle.

Top module: `tod_clock`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `seconds`, `minutes` and `hours` are 0 and `day_carry` is 0.
- R2: In a cycle with `tick` high and `clr` low, `seconds` goes up by one on the clock edge. In a cycle with both low, all three counts keep their values.
- R3: A tick while `seconds` is 59 returns `seconds` to 0 and raises `minutes` by one on the same edge.
- R4: A tick at `mm`=59 and `ss`=59 returns both to 0 and raises `hours` by one on the same edge. `hours` changes on no other cycle except a clear.
- R5: A tick at 23:59:59 gives 00:00:00 on the next edge.
- R6: `clr` high sets all three counts to 0 on the next edge whether or not `tick` is high. A clear with a tick at `ss`=59 leaves `minutes` at 0.
- R7: `day_carry` is high, with no register delay, exactly when `tick` is high, `clr` is low and the time is 23:59:59. With `tick` low, or with `clr` high, it is 0 at 23:59:59.
- R8: Each count stays below its modulus: `seconds` below 60, `minutes` below 60, `hours` below 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all stages; overrides `tick` |
| tick | input | 1 | One-cycle request to advance by one second |
| seconds | output | 6 | Seconds count, 0 to 59 |
| minutes | output | 6 | Minutes count, 0 to 59 |
| hours | output | 5 | Hours count, 0 to 23 |
| day_carry | output | 1 | Combinational wrap of the hours stage |

## Verification
`day_carry` is combinational, so its value is due in the same cycle as the tick that causes it. The count outputs are registered and are due one edge after the stimulus, carry included.

The bench drives its inputs on the falling edge and reads `day_carry` one nanosecond later, inside that same cycle. It reads the counts at the next falling edge, after exactly one rising edge has passed. Long runs hold `tick` high for a known number of rising edges, so the expected time is the tick count converted to hours, minutes and seconds.

// File: rtl/tod_pkg.sv
package tod_pkg;

   // default moduli of the three stages, lowest first
   localparam int SEC_MODULUS  = 60;
   localparam int MIN_MODULUS  = 60;
   localparam int HOUR_MODULUS = 24;

   // register width needed to hold 0 .. modulus-1
   function automatic int stage_width(input int modulus);
      return (modulus > 1) ? $clog2(modulus) : 1;
   endfunction

   // true when the modulus is a power of two
   function automatic bit is_pow2(input int modulus);
      return (modulus > 0) && ((modulus & (modulus - 1)) == 0);
   endfunction

endpackage

// File: rtl/tod_digit.sv
module tod_digit
   import tod_pkg::*;
#(
   parameter  int MODULUS = 10,
   localparam int W       = stage_width(MODULUS)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] value,
   output logic         wrap
);

   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   logic         at_last;
   logic [W-1:0] nxt;

   generate
      if (MODULUS < 2) begin : g_bad_modulus
         $error("tod_digit: MODULUS must be at least 2");
      end

      if (is_pow2(MODULUS)) begin : g_pow2
         // natural binary wrap, terminal count is all ones
         assign at_last = &value;
         assign nxt     = value + 1'b1;
      end else begin : g_compare
         assign at_last = (value == LAST);
         assign nxt     = at_last ? '0 : value + 1'b1;
      end
   endgenerate

   // Mealy rollover: input qualified terminal count
   assign wrap = inc & ~clr & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (clr) begin
         value <= '0;
      end else if (inc) begin
         value <= nxt;
      end
   end

   // R8: count never leaves 0 .. MODULUS-1
   a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      value <= LAST);

   // R6: clear wins over increment
   a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (value == '0));

   // R2: idle cycle keeps the count
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !clr) |=> $stable(value));

   // R2: increment below terminal count adds one
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && value != LAST) |=> (value == W'($past(value) + 1'b1)));

   // R3: a wrapping stage lands on zero
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (value == '0));

   // R7: wrap needs a request and no clear
   a_r7_wrap_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (inc && !clr && value == LAST));

endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter  int SEC_MOD  = SEC_MODULUS,
   parameter  int MIN_MOD  = MIN_MODULUS,
   parameter  int HOUR_MOD = HOUR_MODULUS,
   localparam int SEC_W    = stage_width(SEC_MOD),
   localparam int MIN_W    = stage_width(MIN_MOD),
   localparam int HOUR_W   = stage_width(HOUR_MOD)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   output logic [SEC_W-1:0]  seconds,
   output logic [MIN_W-1:0]  minutes,
   output logic [HOUR_W-1:0] hours,
   output logic              day_carry
);

   logic sec_wrap;
   logic min_wrap;

   tod_digit #(.MODULUS(SEC_MOD)) u_sec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (tick),
      .value (seconds),
      .wrap  (sec_wrap)
   );

   tod_digit #(.MODULUS(MIN_MOD)) u_min (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (sec_wrap),
      .value (minutes),
      .wrap  (min_wrap)
   );

   tod_digit #(.MODULUS(HOUR_MOD)) u_hour (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (min_wrap),
      .value (hours),
      .wrap  (day_carry)
   );

   // R7: day carry only on a live tick
   a_r7_carry_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      day_carry |-> (tick && !clr));

   // R3: minutes move only through a seconds wrap or a clear
   a_r3_minutes_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(sec_wrap)) |-> $stable(minutes));

   // R4: hours move only through a minutes wrap or a clear
   a_r4_hours_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(min_wrap)) |-> $stable(hours));

   // R5: a day carry leaves the whole clock at zero
   a_r5_day_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      day_carry |=> (seconds == '0 && minutes == '0 && hours == '0));

endmodule

// File: tb/test_tod_clock.sv
module test_tod_clock;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clr = 1'b0;
   logic       tick = 1'b0;
   logic [5:0] seconds;
   logic [5:0] minutes;
   logic [4:0] hours;
   logic       day_carry;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   tod_clock i_tod_clock (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .tick      (tick),
      .seconds   (seconds),
      .minutes   (minutes),
      .hours     (hours),
      .day_carry (day_carry)
   );

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic check_time(input string req, input int h, input int m, input int s);
      check({req, " hours"},   int'(hours),   h);
      check({req, " minutes"}, int'(minutes), m);
      check({req, " seconds"}, int'(seconds), s);
   endtask

   // one cycle: drive at falling edge, read carry at once, return after one rising edge
   task automatic one_cycle(input logic t, input logic c, output logic carry);
      @(negedge clk);
      tick = t;
      clr  = c;
      #1 carry = day_carry;
      @(negedge clk);
      tick = 1'b0;
      clr  = 1'b0;
   endtask

   // hold tick high for n rising edges
   task automatic burst(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic t_reset;
      logic cy;
      @(negedge clk);
      check_time("R1 in reset", 0, 0, 0);
      check("R1 carry in reset", int'(day_carry), 0);
      rst_n = 1'b1;
      one_cycle(1'b0, 1'b0, cy);
      check_time("R1 after release", 0, 0, 0);
      check("R1 carry after release", int'(cy), 0);
   endtask

   task automatic t_idle_and_step;
      logic cy;
      for (int i = 0; i < 4; i++) one_cycle(1'b0, 1'b0, cy);
      check_time("R2 idle hold", 0, 0, 0);
      for (int i = 0; i < 7; i++) one_cycle(1'b1, 1'b0, cy);
      check_time("R2 seven ticks", 0, 0, 7);
      one_cycle(1'b0, 1'b0, cy);
      check_time("R2 hold after ticks", 0, 0, 7);
   endtask

   task automatic t_clear_priority;
      logic cy;
      one_cycle(1'b1, 1'b1, cy);
      check_time("R6 clr with tick", 0, 0, 0);
      check("R6 carry during clr", int'(cy), 0);
   endtask

   task automatic t_seconds_wrap;
      logic cy;
      burst(59);
      check_time("R3 before wrap", 0, 0, 59);
      one_cycle(1'b1, 1'b1, cy);
      check_time("R6 clr at ss 59", 0, 0, 0);
      burst(59);
      one_cycle(1'b1, 1'b0, cy);
      check_time("R3 seconds wrap", 0, 1, 0);
      burst(125);
      check_time("R3 mixed run", 0, 3, 5);
   endtask

   task automatic t_hour_carry;
      logic cy;
      one_cycle(1'b0, 1'b1, cy);
      burst(3599);
      check_time("R4 before hour", 0, 59, 59);
      one_cycle(1'b1, 1'b0, cy);
      check_time("R4 hour step", 1, 0, 0);
      check("R7 no carry at hour", int'(cy), 0);
   endtask

   task automatic t_day_wrap;
      logic cy;
      one_cycle(1'b0, 1'b1, cy);
      burst(86399);
      check_time("R8 end of day", 23, 59, 59);
      one_cycle(1'b0, 1'b0, cy);
      check("R7 no carry without tick", int'(cy), 0);
      check_time("R2 hold at end of day", 23, 59, 59);
      one_cycle(1'b1, 1'b0, cy);
      check("R7 carry on day wrap", int'(cy), 1);
      check_time("R5 day wrap", 0, 0, 0);
      one_cycle(1'b0, 1'b0, cy);
      check("R7 carry lasts one cycle", int'(cy), 0);
      one_cycle(1'b1, 1'b0, cy);
      check("R7 no carry at 00:00:00", int'(cy), 0);
      check_time("R5 after wrap", 0, 0, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_idle_and_step();
      t_clear_priority();
      t_seconds_wrap();
      t_hour_carry();
      t_day_wrap();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule